// File: doc/BRIEF.md
# Microcoded Accumulator Processor on a Shared Byte Bus

This block is a small 8-bit accumulator processor. Every transfer between its registers moves over one byte-wide bus, and that bus carries both data and memory addresses. The sources on the bus are the program counter, the memory read port, the switch input, the accumulator and the adder output. Each one drives the bus only while its own enable strobe is set. A microcoded sequencer produces a struct of strobes in every cycle. Each strobe selects one bus source and the registers that capture the bus at the next clock edge.

An instruction is fetched from the 256-byte internal memory in two micro-steps. The first moves the program counter into the address register and increments the program counter. The second reads memory onto the bus and loads the instruction register. During that second step the sequencer branches on the three most significant bits of the byte being loaded. Four instructions carry a second byte that holds a memory address. This byte is fetched the same way and then moved into the address register.

The surrounding system, or a testbench, fills memory through a host write port while reset is held. It can read any memory byte through a combinational host read port.

Top module: `acc_bus_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, LED register, instruction register, address register and both adder operand buffers, and points the sequencer at the first fetch step. Execution then begins at memory address 00h.
- R2: A byte whose bits [7:5] are 001 (for example 20h) is a one-byte instruction that copies `swIn` into the accumulator. It takes 3 cycles.
- R3: A byte whose bits [7:5] are 010 (for example 40h), followed by an address byte A, sets the accumulator to accumulator + mem[A] modulo 256, with no carry kept. The sequence loads the accumulator into one operand buffer and mem[A] into the other, then writes the sum back. It takes 7 cycles.
- R4: At most one bus source enable (`busEn` bits: 4 = program counter, 3 = memory, 2 = switch, 1 = accumulator, 0 = adder) is active in any cycle.
- R5: Each fetched instruction or address byte increments the program counter by one, wrapping modulo 256.
- R6: A byte whose bits [7:5] are 011 (for example 60h), followed by address A, writes the accumulator into mem[A]. It takes 5 cycles.
- R7: A byte whose bits [7:5] are 100 (for example 80h), followed by address A, loads mem[A] into the LED register (`ledOut`). It takes 5 cycles. The LED register holds its value under every other instruction.
- R8: A byte whose bits [7:5] are 101 (for example A0h), followed by address A, loads A into the program counter. It takes 4 cycles.
- R9: A byte whose bits [7:5] are 000, 110 or 111 returns to fetch after its 2-cycle fetch. It changes neither the accumulator nor the LED register nor memory, and advances the program counter by exactly one.
- R10: Bits [4:0] of an instruction byte have no effect on which instruction executes.
- R11: The five-instruction loop "IN; ADD 10h; STA 11h; OUT 11h; JMP 00h" completes in 24 cycles. It leaves `ledOut` and mem[11h] equal to `swIn` + mem[10h] modulo 256 and the program counter at 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| swIn | input | 8 | Switch input byte |
| hostWe | input | 1 | Host memory write strobe, used while reset is held |
| hostAddr | input | 8 | Host memory address for writes and reads |
| hostWdata | input | 8 | Host memory write data |
| hostRdata | output | 8 | Memory byte at `hostAddr`, combinational |
| ledOut | output | 8 | LED output register |
| accOut | output | 8 | Accumulator value |
| pcOut | output | 8 | Program counter value |
| busEn | output | 5 | Bus source enables (program counter, memory, switch, accumulator, adder) |

## Verification
The assertions assume that `swIn` stays stable while the processor runs and that `hostWe` is used only while `rst` is high. Under those conditions a processor write can never collide with a host write. The stimulus loads every program with reset held and releases reset only after loading is complete. It changes `swIn` only between runs, and during execution it only drives `hostAddr` to read memory. Programs and data sweep the switch value and the memory operand across the byte range, including sums that wrap. Extra programs use the undefined opcode classes, opcodes with their low bits set, and a jump to a nonzero address.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int UAW = 5;
  localparam int OPW = 3;

  // One strobe per bus source enable and per register load
  typedef struct packed {
    logic pcOe;
    logic ramOe;
    logic swOe;
    logic r0Oe;
    logic aluOe;
    logic ldAr;
    logic ldIr;
    logic ldR0;
    logic ldDr1;
    logic ldDr2;
    logic ldPc;
    logic incPc;
    logic ramWe;
    logic ldLed;
  } strobe_t;

  typedef struct packed {
    strobe_t        s;
    logic           dispatch;
    logic [UAW-1:0] next;
  } uword_t;

  // Instruction classes decoded from the top opcode bits
  typedef enum logic [OPW-1:0] {
    OP_IN  = 3'd1,
    OP_ADD = 3'd2,
    OP_STA = 3'd3,
    OP_OUT = 3'd4,
    OP_JMP = 3'd5
  } opclass_t;

  // Micro-program entry points
  localparam logic [UAW-1:0] U_FETCH = 5'd0;
  localparam logic [UAW-1:0] U_DISP  = 5'd1;
  localparam logic [UAW-1:0] U_IN    = 5'd2;
  localparam logic [UAW-1:0] U_ADD   = 5'd3;
  localparam logic [UAW-1:0] U_STA   = 5'd8;
  localparam logic [UAW-1:0] U_OUT   = 5'd11;
  localparam logic [UAW-1:0] U_JMP   = 5'd14;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opTop,
  output strobe_t        st
);

  logic [UAW-1:0] uAddr;
  logic [UAW-1:0] uNext;
  uword_t         uw;

  // Control store contents, computed as a function of the micro-address
  function automatic uword_t romWord(input logic [UAW-1:0] a);
    uword_t w;
    w = '0;
    case (a)
      5'd0:  begin w.s.pcOe = 1'b1; w.s.ldAr = 1'b1; w.s.incPc = 1'b1; w.next = U_DISP; end
      5'd1:  begin w.s.ramOe = 1'b1; w.s.ldIr = 1'b1; w.dispatch = 1'b1; end
      // single-byte input
      5'd2:  begin w.s.swOe = 1'b1; w.s.ldR0 = 1'b1; w.next = U_FETCH; end
      // add: fetch operand address, move it to AR, fill buffers, write sum
      5'd3:  begin w.s.pcOe = 1'b1; w.s.ldAr = 1'b1; w.s.incPc = 1'b1; w.next = 5'd4; end
      5'd4:  begin w.s.ramOe = 1'b1; w.s.ldAr = 1'b1; w.next = 5'd5; end
      5'd5:  begin w.s.r0Oe = 1'b1; w.s.ldDr2 = 1'b1; w.next = 5'd6; end
      5'd6:  begin w.s.ramOe = 1'b1; w.s.ldDr1 = 1'b1; w.next = 5'd7; end
      5'd7:  begin w.s.aluOe = 1'b1; w.s.ldR0 = 1'b1; w.next = U_FETCH; end
      // store
      5'd8:  begin w.s.pcOe = 1'b1; w.s.ldAr = 1'b1; w.s.incPc = 1'b1; w.next = 5'd9; end
      5'd9:  begin w.s.ramOe = 1'b1; w.s.ldAr = 1'b1; w.next = 5'd10; end
      5'd10: begin w.s.r0Oe = 1'b1; w.s.ramWe = 1'b1; w.next = U_FETCH; end
      // output to LEDs
      5'd11: begin w.s.pcOe = 1'b1; w.s.ldAr = 1'b1; w.s.incPc = 1'b1; w.next = 5'd12; end
      5'd12: begin w.s.ramOe = 1'b1; w.s.ldAr = 1'b1; w.next = 5'd13; end
      5'd13: begin w.s.ramOe = 1'b1; w.s.ldLed = 1'b1; w.next = U_FETCH; end
      // jump
      5'd14: begin w.s.pcOe = 1'b1; w.s.ldAr = 1'b1; w.s.incPc = 1'b1; w.next = 5'd15; end
      5'd15: begin w.s.ramOe = 1'b1; w.s.ldPc = 1'b1; w.next = U_FETCH; end
      default: w.next = U_FETCH;
    endcase
    return w;
  endfunction

  function automatic logic [UAW-1:0] entryFor(input logic [OPW-1:0] op);
    case (op)
      OP_IN:   return U_IN;
      OP_ADD:  return U_ADD;
      OP_STA:  return U_STA;
      OP_OUT:  return U_OUT;
      OP_JMP:  return U_JMP;
      default: return U_FETCH;
    endcase
  endfunction

  always_comb begin
    uw    = romWord(uAddr);
    st    = uw.s;
    uNext = uw.dispatch ? entryFor(opTop) : uw.next;
  end

  always_ff @(posedge clk) begin
    if (rst) uAddr <= U_FETCH;
    else     uAddr <= uNext;
  end

  // R9: an undefined class leaves dispatch straight back to fetch
  p_undef_to_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (uAddr == U_DISP && (opTop == 3'd0 || opTop > 3'd5)) |=> (uAddr == U_FETCH));

  // R5: fetch step is always followed by dispatch step
  p_fetch_then_disp_r5: assert property (@(posedge clk) disable iff (rst)
    (uAddr == U_FETCH) |=> (uAddr == U_DISP));

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        st,
  input  logic [DW-1:0]  swIn,
  input  logic           hostWe,
  input  logic [DW-1:0]  hostAddr,
  input  logic [DW-1:0]  hostWdata,
  output logic [DW-1:0]  hostRdata,
  output logic [OPW-1:0] opTop,
  output logic [DW-1:0]  ledOut,
  output logic [DW-1:0]  accOut,
  output logic [DW-1:0]  pcOut,
  output logic [4:0]     busEn
);

  // Addresses travel on the data bus, so address width equals data width
  localparam int DEPTH = 1 << DW;

  logic [DW-1:0] pc, ar, ir, r0, dr1, dr2, led;
  logic [DW-1:0] bus;
  logic [DW-1:0] aluSum;
  logic [DW-1:0] mem [DEPTH];

  assign aluSum = DW'(dr1 + dr2);
  assign busEn  = {st.pcOe, st.ramOe, st.swOe, st.r0Oe, st.aluOe};

  // Bus: each source contributes only when its enable is set
  always_comb begin
    bus = '0;
    if (st.pcOe)  bus = bus | pc;
    if (st.ramOe) bus = bus | mem[ar];
    if (st.swOe)  bus = bus | swIn;
    if (st.r0Oe)  bus = bus | r0;
    if (st.aluOe) bus = bus | aluSum;
  end

  // Opcode class seen by the sequencer during the dispatch step
  assign opTop = st.ldIr ? bus[DW-1 -: OPW] : ir[DW-1 -: OPW];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      r0  <= '0;
      dr1 <= '0;
      dr2 <= '0;
      led <= '0;
    end else begin
      if (st.ldPc)       pc <= bus;
      else if (st.incPc) pc <= DW'(pc + 1'b1);
      if (st.ldAr)  ar  <= bus;
      if (st.ldIr)  ir  <= bus;
      if (st.ldR0)  r0  <= bus;
      if (st.ldDr1) dr1 <= bus;
      if (st.ldDr2) dr2 <= bus;
      if (st.ldLed) led <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (hostWe)        mem[hostAddr] <= hostWdata;
    else if (st.ramWe) mem[ar]       <= bus;
  end

  assign hostRdata = mem[hostAddr];
  assign ledOut    = led;
  assign accOut    = r0;
  assign pcOut     = pc;

  // R4: exclusive bus drivers
  p_bus_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busEn));

  // R5: increment strobe advances the program counter by one
  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (st.incPc && !st.ldPc) |=> (pc == DW'($past(pc) + 1'b1)));

  // R2: input transfer lands the switch byte in the accumulator
  p_in_copy_r2: assert property (@(posedge clk) disable iff (rst)
    (st.swOe && st.ldR0) |=> (r0 == $past(swIn)));

  // R3: sum written back is the modulo sum of both buffers
  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (st.aluOe && st.ldR0) |=> (r0 == DW'($past(dr1) + $past(dr2))));

  // R7: LED register holds unless loaded
  p_led_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !st.ldLed |=> $stable(led));

endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] swIn,
  input  logic       hostWe,
  input  logic [7:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic [7:0] ledOut,
  output logic [7:0] accOut,
  output logic [7:0] pcOut,
  output logic [4:0] busEn
);

  strobe_t        st;
  logic [OPW-1:0] opTop;

  acc_cpu_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .opTop (opTop),
    .st    (st)
  );

  acc_cpu_dpath #(.DW(8)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .swIn      (swIn),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .opTop     (opTop),
    .ledOut    (ledOut),
    .accOut    (accOut),
    .pcOut     (pcOut),
    .busEn     (busEn)
  );

endmodule

// File: tb/sim_acc_bus_cpu.sv
module sim_acc_bus_cpu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] swIn = '0;
  logic       hostWe = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata, ledOut, accOut, pcOut;
  logic [4:0] busEn;

  int checks = 0;
  int fails = 0;
  int conflicts = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_bus_cpu u0 (
    .clk(clk), .rst(rst), .swIn(swIn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ledOut(ledOut),
    .accOut(accOut), .pcOut(pcOut), .busEn(busEn)
  );

  // R4 monitor: count cycles with more than one bus source
  always @(negedge clk) begin
    if (!rst && $countones(busEn) > 1) conflicts++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic check_conflicts();
    chk(conflicts == 0, "R4 bus exclusive", conflicts, 0);
    conflicts = 0;
  endtask

  // Main loop program with operand m and switch s
  task automatic run_loop(input logic [7:0] s, input logic [7:0] m);
    logic [7:0] sum;
    logic [7:0] rd;
    sum = s + m;
    @(negedge clk);
    rst = 1'b1;
    swIn = s;
    poke(8'h00, 8'h20); poke(8'h01, 8'h40); poke(8'h02, 8'h10);
    poke(8'h03, 8'h60); poke(8'h04, 8'h11); poke(8'h05, 8'h80);
    poke(8'h06, 8'h11); poke(8'h07, 8'hA0); poke(8'h08, 8'h00);
    poke(8'h10, m);     poke(8'h11, ~sum);
    // R1 reset state
    chk(ledOut == 0 && accOut == 0 && pcOut == 0, "R1 reset state",
        {ledOut, accOut, pcOut}, 0);
    rst = 1'b0;
    tick(3);
    chk(accOut == s, "R2 IN result", accOut, s);
    chk(pcOut == 8'h01, "R5 pc after IN", pcOut, 1);
    tick(7);
    chk(accOut == sum, "R3 ADD modulo sum", accOut, sum);
    chk(pcOut == 8'h03, "R5 pc after ADD", pcOut, 3);
    tick(5);
    peek(8'h11, rd);
    chk(rd == sum, "R6 STA memory", rd, sum);
    chk(ledOut == 8'h00, "R7 LED held before OUT", ledOut, 0);
    tick(5);
    chk(ledOut == sum, "R7 OUT to LED", ledOut, sum);
    tick(4);
    chk(pcOut == 8'h00, "R8 R11 JMP back after 24 cycles", pcOut, 0);
    tick(24);
    chk(ledOut == sum && accOut == sum, "R11 second loop", ledOut, sum);
    check_conflicts();
  endtask

  // Undefined opcodes, low-bit variants and a nonzero jump target
  task automatic run_odd(input logic [7:0] s, input logic [7:0] m);
    logic [7:0] sum;
    logic [7:0] rd;
    sum = s + m;
    @(negedge clk);
    rst = 1'b1;
    swIn = s;
    poke(8'h00, 8'hC7); poke(8'h01, 8'h1F); poke(8'h02, 8'hE0);
    poke(8'h03, 8'h3F); poke(8'h04, 8'h5F); poke(8'h05, 8'h10);
    poke(8'h06, 8'hBF); poke(8'h07, 8'h09); poke(8'h09, 8'h9A);
    poke(8'h0A, 8'h10); poke(8'h0B, 8'hA3); poke(8'h0C, 8'h00);
    poke(8'h10, m);
    peek(8'h0A, rd);
    rst = 1'b0;
    tick(2);
    chk(pcOut == 8'h01 && accOut == 0, "R9 undefined 110 class", pcOut, 1);
    tick(2);
    chk(pcOut == 8'h02 && accOut == 0, "R9 undefined 000 class", pcOut, 2);
    tick(2);
    chk(pcOut == 8'h03 && accOut == 0 && ledOut == 0, "R9 undefined 111 class", accOut, 0);
    tick(3);
    chk(accOut == s, "R10 IN with low bits set", accOut, s);
    tick(7);
    chk(accOut == sum, "R10 ADD with low bits set", accOut, sum);
    tick(4);
    chk(pcOut == 8'h09, "R8 JMP nonzero target", pcOut, 9);
    tick(5);
    chk(ledOut == m, "R10 OUT with low bits set", ledOut, m);
    tick(4);
    chk(pcOut == 8'h00, "R8 JMP low bits set", pcOut, 0);
    tick(6);
    chk(accOut == sum && ledOut == m && pcOut == 8'h03, "R9 undefined keeps acc and LED",
        accOut, sum);
    peek(8'h0A, rd);
    chk(rd == 8'h10, "R9 memory untouched", rd, 8'h10);
    check_conflicts();
  endtask

  initial begin
    logic [7:0] mv [6];
    mv[0] = 8'h00; mv[1] = 8'h01; mv[2] = 8'h7F;
    mv[3] = 8'h80; mv[4] = 8'hFF; mv[5] = 8'h5A;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i += 15) begin
      for (int j = 0; j < 6; j++) begin
        run_loop(8'(i), mv[j]);
      end
    end
    run_loop(8'hFF, 8'hFF);
    for (int j = 0; j < 6; j++) begin
      run_odd(8'(37 * j + 200), mv[j]);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule